// File: doc/BRIEF.md
# External Interrupt Request Controller

This block gathers six active-low external interrupt pins and turns them into one prioritised request for a CPU core. Each pin can be set to follow the pin level or to catch a falling edge. Each pin also has a 4-bit priority. Pending requests are visible in a request register. Software clears an edge-latched request with a read-then-write-zero handshake. A level request clears by itself once the pin goes high again.

Every cycle the block chooses the most urgent pending request and compares its priority with the CPU's current mask level. It presents the request, its level and its source number on registered outputs. The block only reads the mask and never modifies it. While the chip is in standby, sources 0 to 4 can raise a wake signal for the standby controller. A small word-wide register port gives access to the sense, priority and request registers.

Top module: `xirq_ctrl`

## Requirements
- R1: After reset, irq_req, irq_level, irq_src and wake are 0, and the sense, priority and request registers all read 0 (every source in level mode with priority 0).
- R2: A source in level mode (sense bit = 0) reads as pending in request register bit i for as long as its synchronized pin is low. It stops being pending once the pin is high, without any software clear.
- R3: A source in edge mode (sense bit = 1) latches its pending bit on a falling edge of its synchronized pin. The bit stays set after the pin returns high.
- R4: Writing 0 to an edge pending bit clears it only if a read of the request register since the previous request-register write returned that bit as 1. A write of 0 without such a read leaves the bit set, and writing 1 never changes it.
- R5: A request is presented only when the pending source's priority is strictly greater than cpu_mask. A priority of 0 disables the source.
- R6: Among pending enabled sources the highest priority wins. On equal priority the lower-numbered source wins.
- R7: irq_level carries the winner's priority and irq_src its number. Both are 0 when irq_req is 0.
- R8: wake is high only while standby is high and some source numbered 0 to 4 is pending with priority above cpu_mask. Source 5 never causes wake.
- R9: An edge is recognised only after the pin has stayed low for at least 3 clock cycles following a high. A 2-cycle low pulse sets nothing.
- R10: Register addresses are sense = 0 (bit i per source), priority = 1 (bits 4i+3..4i for source i), request = 2 (bit i per source). Written values read back unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_pin_n | input | 6 | External interrupt pins, active low, asynchronous |
| cpu_mask | input | 4 | Current CPU interrupt mask level |
| standby | input | 1 | Chip is in standby |
| reg_addr | input | 2 | Register select |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the selected register |
| irq_req | output | 1 | Interrupt request to the CPU |
| irq_level | output | 4 | Priority of the presented request |
| irq_src | output | 3 | Number of the presented source |
| wake | output | 1 | Wake request to the standby controller |

## Verification
The bench writes 0 to a latched edge request both without and after a read that returned 1. A design that ignored the read handshake would clear the bit too early or never clear it. It drives 2-cycle and 4-cycle low pulses in edge mode, so a missing pulse filter shows up as a spurious request. It sets equal priorities and a priority equal to the mask, which catches a wrong tie rule or a non-strict compare. It also holds source 5 pending in standby, which catches a wake path that covers every source.

// File: rtl/xirq_pkg.sv
package xirq_pkg;
  localparam int NUM_SRC = 6;
  localparam int PRIO_W  = 4;
  localparam int DATA_W  = 32;
  localparam int ADDR_W  = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_SENSE = 2'd0,
    REG_PRIO  = 2'd1,
    REG_PEND  = 2'd2
  } reg_sel_e;
endpackage

// File: rtl/xirq_chan.sv
module xirq_chan #(
  parameter int EDGE_MIN = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_n,
  input  logic edge_mode,
  input  logic rd_pend,
  input  logic wr_pend,
  input  logic wr_bit,
  output logic pend
);
  logic s1_q, s2_q;
  logic [EDGE_MIN-1:0] hist_q, hist_d;
  logic latch_q, latch_d;
  logic arm_q, arm_d;
  logic fall;
  logic clr;

  // fall: oldest sample high, the newest EDGE_MIN samples low
  always_comb begin
    hist_d  = {hist_q[EDGE_MIN-2:0], s2_q};
    fall    = hist_q[EDGE_MIN-1] && (hist_q[EDGE_MIN-2:0] == '0) && !s2_q;
    clr     = wr_pend && arm_q && !wr_bit;
    latch_d = latch_q;
    if (clr) latch_d = 1'b0;
    if (fall && edge_mode) latch_d = 1'b1;
    arm_d = arm_q;
    if (wr_pend) arm_d = 1'b0;
    else if (rd_pend && edge_mode && latch_q) arm_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q    <= 1'b1;
      s2_q    <= 1'b1;
      hist_q  <= '1;
      latch_q <= 1'b0;
      arm_q   <= 1'b0;
    end else begin
      s1_q    <= pin_n;
      s2_q    <= s1_q;
      hist_q  <= hist_d;
      latch_q <= latch_d;
      arm_q   <= arm_d;
    end
  end

  assign pend = edge_mode ? latch_q : !s2_q;

  // R4: a latched request survives unless an armed zero-write hits it
  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_q && !(wr_pend && arm_q && !wr_bit)) |=> latch_q);

  // R4: clearing needs a prior arming read
  p_arm_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_q && !arm_q && !(fall && edge_mode)) |=> latch_q);
endmodule

// File: rtl/xirq_regs.sv
module xirq_regs
  import xirq_pkg::*;
#(
  parameter int N  = NUM_SRC,
  parameter int PW = PRIO_W,
  parameter int DW = DATA_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic            wr,
  input  logic            rd,
  input  logic [DW-1:0]   wdata,
  input  logic [N-1:0]    pend,
  output logic [DW-1:0]   rdata,
  output logic [N-1:0]    sense,
  output logic [N*PW-1:0] prio,
  output logic            rd_pend,
  output logic            wr_pend
);
  logic [N-1:0]    sense_d;
  logic [N*PW-1:0] prio_d;
  logic            sense_en, prio_en;

  always_comb begin
    sense_en = wr && (addr == REG_SENSE);
    prio_en  = wr && (addr == REG_PRIO);
    wr_pend  = wr && (addr == REG_PEND);
    rd_pend  = rd && (addr == REG_PEND);
    sense_d  = sense_en ? wdata[N-1:0] : sense;
    prio_d   = prio_en ? wdata[N*PW-1:0] : prio;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sense <= '0;
      prio  <= '0;
    end else begin
      sense <= sense_d;
      prio  <= prio_d;
    end
  end

  always_comb begin
    rdata = '0;
    unique case (addr)
      REG_SENSE: rdata[N-1:0]    = sense;
      REG_PRIO:  rdata[N*PW-1:0] = prio;
      REG_PEND:  rdata[N-1:0]    = pend;
      default:   rdata           = '0;
    endcase
  end
endmodule

// File: rtl/xirq_arb.sv
module xirq_arb #(
  parameter int N       = 6,
  parameter int PW      = 4,
  parameter int SW      = 3,
  parameter logic [N-1:0] WAKE_EN = '1
) (
  input  logic [N-1:0]    pend,
  input  logic [N*PW-1:0] prio,
  input  logic [PW-1:0]   mask,
  output logic            req,
  output logic [PW-1:0]   level,
  output logic [SW-1:0]   src,
  output logic            wake_any
);
  logic [PW-1:0] best;
  logic [SW-1:0] best_src;

  // descending scan with >= lets the lower index win ties
  always_comb begin
    best     = '0;
    best_src = '0;
    wake_any = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (pend[i] && (prio[i*PW +: PW] != '0) && (prio[i*PW +: PW] >= best)) begin
        best     = prio[i*PW +: PW];
        best_src = SW'(i);
      end
      if (WAKE_EN[i] && pend[i] && (prio[i*PW +: PW] > mask))
        wake_any = 1'b1;
    end
    req   = best > mask;
    level = req ? best : '0;
    src   = req ? best_src : '0;
  end
endmodule

// File: rtl/xirq_ctrl.sv
module xirq_ctrl
  import xirq_pkg::*;
#(
  parameter int N        = NUM_SRC,
  parameter int PW       = PRIO_W,
  parameter int DW       = DATA_W,
  parameter int EDGE_MIN = 3,
  parameter logic [N-1:0] WAKE_EN = 6'b011111
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N-1:0]      irq_pin_n,
  input  logic [PW-1:0]     cpu_mask,
  input  logic              standby,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  output logic              irq_req,
  output logic [PW-1:0]     irq_level,
  output logic [$clog2(N)-1:0] irq_src,
  output logic              wake
);
  localparam int SW = $clog2(N);

  logic rst_s1, rst_s2;
  logic [N-1:0]    sense, pend;
  logic [N*PW-1:0] prio;
  logic rd_pend, wr_pend;
  logic          req_d, wake_any, wake_d;
  logic [PW-1:0] lvl_d;
  logic [SW-1:0] src_d;

  // reset asserts at once, releases on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_s2 <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_s2 <= rst_s1;
    end
  end

  xirq_regs #(.N(N), .PW(PW), .DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_s2), .addr(reg_addr), .wr(reg_wr), .rd(reg_rd),
    .wdata(reg_wdata), .pend(pend), .rdata(reg_rdata), .sense(sense),
    .prio(prio), .rd_pend(rd_pend), .wr_pend(wr_pend)
  );

  for (genvar g = 0; g < N; g++) begin : g_chan
    xirq_chan #(.EDGE_MIN(EDGE_MIN)) u_chan (
      .clk(clk), .rst_n(rst_s2), .pin_n(irq_pin_n[g]), .edge_mode(sense[g]),
      .rd_pend(rd_pend), .wr_pend(wr_pend), .wr_bit(reg_wdata[g]),
      .pend(pend[g])
    );
  end

  xirq_arb #(.N(N), .PW(PW), .SW(SW), .WAKE_EN(WAKE_EN)) u_arb (
    .pend(pend), .prio(prio), .mask(cpu_mask), .req(req_d),
    .level(lvl_d), .src(src_d), .wake_any(wake_any)
  );

  assign wake_d = standby && wake_any;

  always_ff @(posedge clk or negedge rst_s2) begin
    if (!rst_s2) begin
      irq_req   <= 1'b0;
      irq_level <= '0;
      irq_src   <= '0;
      wake      <= 1'b0;
    end else begin
      irq_req   <= req_d;
      irq_level <= lvl_d;
      irq_src   <= src_d;
      wake      <= wake_d;
    end
  end

  p_above_mask_r5: assert property (@(posedge clk) disable iff (!rst_s2)
    irq_req |-> (irq_level > $past(cpu_mask)));

  p_idle_zero_r7: assert property (@(posedge clk) disable iff (!rst_s2)
    !irq_req |-> (irq_level == '0 && irq_src == '0));

  p_wake_standby_r8: assert property (@(posedge clk) disable iff (!rst_s2)
    wake |-> $past(standby));

  p_src_range_r6: assert property (@(posedge clk) disable iff (!rst_s2)
    irq_req |-> (int'(irq_src) < N));
endmodule

// File: tb/xirq_ctrl_bench.sv
module xirq_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [5:0]  pin_n;
  logic [3:0]  mask;
  logic        stby;
  logic [1:0]  addr;
  logic        wr, rd;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic        irq_req, wake;
  logic [3:0]  irq_level;
  logic [2:0]  irq_src;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  always #5 clk = ~clk;

  xirq_ctrl u_xirq_ctrl (
    .clk(clk), .rst_n(rst_n), .irq_pin_n(pin_n), .cpu_mask(mask),
    .standby(stby), .reg_addr(addr), .reg_wr(wr), .reg_rd(rd),
    .reg_wdata(wdata), .reg_rdata(rdata), .irq_req(irq_req),
    .irq_level(irq_level), .irq_src(irq_src), .wake(wake)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic reg_write(logic [1:0] a, logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0; wdata = '0;
  endtask

  task automatic reg_read(logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a; rd = 1'b1;
    #1 d = rdata;
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check("R1 irq_req", irq_req, 0);
    check("R1 irq_level", irq_level, 0);
    check("R1 irq_src", irq_src, 0);
    check("R1 wake", wake, 0);
    reg_read(0, d); check("R1 sense", d, 0);
    reg_read(1, d); check("R1 prio", d, 0);
    reg_read(2, d); check("R1 pend", d, 0);
  endtask

  task automatic t_regs();
    logic [31:0] d;
    reg_write(0, 32'h0000_002A);
    reg_write(1, 32'h00AB_CDEF);
    reg_read(0, d); check("R10 sense readback", d, 32'h2A);
    reg_read(1, d); check("R10 prio readback", d, 32'h00AB_CDEF);
    reg_write(0, 0);
    reg_write(1, 0);
  endtask

  task automatic t_level();
    logic [31:0] d;
    reg_write(1, 32'h0000_0500);   // source 2 priority 5
    pin_n[2] = 1'b0;
    wait_cyc(6);
    check("R2 level req", irq_req, 1);
    check("R7 level value", irq_level, 5);
    check("R7 level src", irq_src, 2);
    reg_read(2, d); check("R2 pend live low", d, 32'h4);
    pin_n[2] = 1'b1;
    wait_cyc(6);
    check("R2 released", irq_req, 0);
    reg_read(2, d); check("R2 pend live high", d, 0);
  endtask

  task automatic t_edge();
    logic [31:0] d;
    reg_write(0, 32'h2);           // source 1 edge
    reg_write(1, 32'h70);          // source 1 priority 7
    reg_write(2, 32'h3F);          // disarm everything, no effect
    pin_n[1] = 1'b0; wait_cyc(4); pin_n[1] = 1'b1;
    wait_cyc(8);
    check("R3 edge latched req", irq_req, 1);
    check("R3 edge src", irq_src, 1);
    reg_write(2, 0);
    reg_read(2, d); check("R4 unarmed zero keeps bit", d, 32'h2);
    reg_write(2, 32'h3F);
    reg_read(2, d); check("R4 write one keeps bit", d, 32'h2);
    reg_write(2, 0);
    wait_cyc(3);
    check("R4 armed clear drops req", irq_req, 0);
    reg_read(2, d); check("R4 armed clear pend", d, 0);
  endtask

  task automatic t_filter();
    logic [31:0] d;
    pin_n[1] = 1'b0; wait_cyc(2); pin_n[1] = 1'b1;
    wait_cyc(8);
    check("R9 short pulse no req", irq_req, 0);
    reg_read(2, d); check("R9 short pulse no pend", d, 0);
    pin_n[1] = 1'b0; wait_cyc(3); pin_n[1] = 1'b1;
    wait_cyc(8);
    reg_read(2, d); check("R9 three-cycle pulse pend", d, 32'h2);
    reg_write(2, 0);
    reg_write(0, 0);
    wait_cyc(2);
  endtask

  task automatic t_prio();
    reg_write(1, 32'h0004_4000);   // sources 3 and 4 priority 4
    pin_n[3] = 1'b0; pin_n[4] = 1'b0;
    wait_cyc(6);
    check("R6 tie lower index", irq_src, 3);
    reg_write(1, 32'h0004_4009);   // source 0 priority 9
    pin_n[0] = 1'b0;
    wait_cyc(6);
    check("R6 highest src", irq_src, 0);
    check("R7 highest level", irq_level, 9);
    mask = 4'd9; wait_cyc(3);
    check("R5 equal mask blocks", irq_req, 0);
    mask = 4'd8; wait_cyc(3);
    check("R5 above mask passes", irq_req, 1);
    mask = 4'd0;
    pin_n = 6'h3F;
    reg_write(1, 0);
    pin_n[5] = 1'b0;
    wait_cyc(6);
    check("R5 priority zero disabled", irq_req, 0);
    pin_n[5] = 1'b1;
    wait_cyc(4);
  endtask

  task automatic t_wake();
    stby = 1'b1;
    reg_write(1, 32'h00A0_0000);   // source 5 priority 10
    pin_n[5] = 1'b0;
    wait_cyc(6);
    check("R8 source5 req", irq_req, 1);
    check("R8 source5 no wake", wake, 0);
    reg_write(1, 32'h00A3_0000);   // source 4 priority 3
    pin_n[4] = 1'b0;
    wait_cyc(6);
    check("R8 source4 wake", wake, 1);
    mask = 4'd3; wait_cyc(3);
    check("R8 mask blocks wake", wake, 0);
    mask = 4'd0; wait_cyc(3);
    stby = 1'b0; wait_cyc(3);
    check("R8 no standby no wake", wake, 0);
    pin_n = 6'h3F;
  endtask

  initial begin
    rst_n = 1'b0; pin_n = 6'h3F; mask = 0; stby = 0;
    addr = 0; wr = 0; rd = 0; wdata = 0;
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(4);
    t_reset();
    t_regs();
    t_level();
    t_edge();
    t_filter();
    t_prio();
    t_wake();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule